// File: doc/BRIEF.md
# Clock-Crossing Input Stability Monitor

This block sits in a destination clock domain at the point where a single-bit control signal arrives from an unrelated clock. It carries the signal into the domain through a flop synchronizer, and it also checks whether each level the sender presents lasts long enough to cross reliably. The monitor watches the first synchronizer stage and finds three kinds of fault:

- **Isolated pulse.** A short pulse caught on only one or two rising edges and then withdrawn.
- **Chatter.** A short level that directly follows another short level.
- **Glitch.** A change seen only by an opposite-edge sample and never by a rising edge.

Each fault kind sets its own sticky flag. A saturating counter totals the faults, and a single-cycle clear input empties the flags and the counter. The block is meant for integration and bring-up. It shows whether a sender holds the rule that a level must survive a set number of destination edges, which `STABLE_CYCLES` sets (default 3).

Top module: `cdc_stability_monitor`

## Requirements
- R1: `sync_o` equals the value of `async_i` sampled at the rising edge two edges earlier. The default is `SYNC_STAGES` = 2.
- R2: While `rst_ni` is low, and after it is released, `sync_o`, all three flags and `err_count_o` are 0.
- R3: A level held for at least `STABLE_CYCLES` consecutive rising-edge samples raises no flag and does not change the count. This applies both to a clean transition and to a pulse exactly `STABLE_CYCLES` samples wide.
- R4: A level held for fewer than `STABLE_CYCLES` samples, when the level before it was long enough, is an isolated pulse. The rising edge that samples the return computes the event. `pulse_err_o` goes to 1 one edge after that.
- R5: A short level that directly follows another short level sets `stab_err_o`, one edge after the sample that ends it. An alternating 1,0,1 burst from a long 0 sets both `pulse_err_o` and `stab_err_o`, and the count rises by 2.
- R6: `glitch_err_o` is set at a rising edge when three samples disagree in a specific way. The falling-edge sample between two rising edges differs from both of those rising-edge samples, and the two rising-edge samples are equal.
- R7: The flags are sticky. Once set, a flag stays 1 until `clear_i` is high at a rising edge. That edge sets all flags and the count to 0, and any event detected at that same edge is discarded.
- R8: `err_count_o` rises by one for each pulse, chatter or glitch event. It saturates at 2^`CNT_W`-1 and never decreases except on clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Destination clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| async_i | input | 1 | Raw signal from the foreign domain |
| clear_i | input | 1 | Clears the flags and the count at a rising edge |
| sync_o | output | 1 | Synchronized copy of `async_i` |
| pulse_err_o | output | 1 | Sticky flag: isolated short pulse |
| stab_err_o | output | 1 | Sticky flag: back-to-back short levels |
| glitch_err_o | output | 1 | Sticky flag: change missed by rising edges |
| err_count_o | output | CNT_W | Saturating count of events |

## Verification
The bench targets the run-length boundary with pulses one, two and exactly three edges wide. A design with an off-by-one run counter would either pass the two-edge pulse or flag the legal three-edge pulse. An alternating burst checks that chatter is told apart from an isolated pulse and that both are counted. A design that kept one classification would report only one flag or the wrong count. Half-cycle glitches check that changes invisible to the rising edge are still caught. They are also driven at the same edge as a clear, to check clear priority, and repeated enough times to reach the saturating count limit, where a wrapping counter would return to zero.

// File: rtl/cdc_mon_pkg.sv
package cdc_mon_pkg;
  typedef struct packed {
    logic pulse;
    logic stab;
    logic glitch;
  } viol_t;

  function automatic int unsigned viol_weight(viol_t v);
    return int'(v.pulse) + int'(v.stab) + int'(v.glitch);
  endfunction
endpackage

// File: rtl/cdc_mon_sync.sv
module cdc_mon_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[0] <= 1'b0;
        else         stg_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= 1'b0;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q;
endmodule

// File: rtl/cdc_mon_run.sv
module cdc_mon_run #(
  parameter int STABLE_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_i,
  input  logic prev_i,
  output logic pulse_o,
  output logic stab_o
);
  localparam int RUN_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STABLE_CYCLES);

  // run_q: length of the run that prev_i belongs to, saturating
  logic [RUN_W-1:0] run_q;
  logic             prev_short_q;
  logic             change_c;
  logic             short_c;

  assign change_c = cur_i ^ prev_i;
  assign short_c  = change_c && (run_q < RUN_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= RUN_MAX;
      prev_short_q <= 1'b0;
    end else if (change_c) begin
      run_q        <= RUN_W'(1);
      prev_short_q <= short_c;
    end else if (run_q != RUN_MAX) begin
      run_q <= run_q + RUN_W'(1);
    end
  end

  assign pulse_o = short_c && !prev_short_q;
  assign stab_o  = short_c &&  prev_short_q;

  // events only at a sampled change of the first stage
  assert_evt_on_change_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o || stab_o) |-> (cur_i != $past(cur_i)));
endmodule

// File: rtl/cdc_mon_glitch.sv
module cdc_mon_glitch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic cur_i,
  output logic glitch_o
);
  logic neg_q;

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= d_i;

  // mid-cycle sample disagrees with both surrounding rising-edge samples
  assign glitch_o = (neg_q != cur_i) && (d_i == cur_i);
endmodule

// File: rtl/cdc_mon_log.sv
module cdc_mon_log
  import cdc_mon_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  viol_t            evt_i,
  input  logic             clear_i,
  output viol_t            flags_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W+1:0] CNT_MAX = {2'b00, {CNT_W{1'b1}}};

  viol_t            flags_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W+1:0] sum_c;

  assign sum_c = {2'b00, cnt_q} + (CNT_W+2)'(viol_weight(evt_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      flags_q <= '0;
      cnt_q   <= '0;
    end else begin
      flags_q <= flags_q | evt_i;
      cnt_q   <= (sum_c > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum_c[CNT_W-1:0];
    end
  end

  assign flags_o = flags_q;
  assign count_o = cnt_q;

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags_o && !clear_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (flags_o == '0 && count_o == '0));
  assert_cnt_mono_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (count_o >= $past(count_o)));
  assert_flag_counted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags_o) |-> (count_o != '0));
endmodule

// File: rtl/cdc_stability_monitor.sv
module cdc_stability_monitor
  import cdc_mon_pkg::*;
#(
  parameter int STABLE_CYCLES = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int CNT_W         = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             async_i,
  input  logic             clear_i,
  output logic             sync_o,
  output logic             pulse_err_o,
  output logic             stab_err_o,
  output logic             glitch_err_o,
  output logic [CNT_W-1:0] err_count_o
);
  localparam int STG = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [STG-1:0] stg;
  viol_t          evt;
  viol_t          flags;

  cdc_mon_sync #(.STAGES(STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_i),
    .q_o   (stg)
  );

  cdc_mon_run #(.STABLE_CYCLES(STABLE_CYCLES)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (stg[0]),
    .prev_i (stg[1]),
    .pulse_o(evt.pulse),
    .stab_o (evt.stab)
  );

  cdc_mon_glitch u_glitch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (async_i),
    .cur_i   (stg[0]),
    .glitch_o(evt.glitch)
  );

  cdc_mon_log #(.CNT_W(CNT_W)) u_log (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clear_i(clear_i),
    .flags_o(flags),
    .count_o(err_count_o)
  );

  assign sync_o       = stg[STG-1];
  assign pulse_err_o  = flags.pulse;
  assign stab_err_o   = flags.stab;
  assign glitch_err_o = flags.glitch;

  if (STG == 2) begin : g_two_stage_chk
    assert_sync_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni, 1) && $past(rst_ni, 2)) |-> (sync_o == $past(async_i, 2)));
  end
endmodule

// File: tb/cdc_stability_monitor_test.sv
`timescale 1ns/1ps
module cdc_stability_monitor_test;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          async_in = 1'b0;
  logic          clr = 1'b0;
  logic          sync_out, p_err, s_err, g_err;
  logic [CW-1:0] cnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cdc_stability_monitor #(.STABLE_CYCLES(3), .SYNC_STAGES(2), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .async_i(async_in), .clear_i(clr),
    .sync_o(sync_out), .pulse_err_o(p_err), .stab_err_o(s_err),
    .glitch_err_o(g_err), .err_count_o(cnt)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drive(logic v, int n);
    async_in = v;
    step(n);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    step(1);
    clr = 1'b0;
  endtask

  task automatic glitch_once();
    async_in = 1'b1;
    #2;
    async_in = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    step(3);
    check("R2 sync", int'(sync_out), 0);
    check("R2 flags", int'({p_err, s_err, g_err}), 0);
    rst_n = 1'b1;
    step(2);
    check("R2 flags after release", int'({p_err, s_err, g_err}), 0);
    check("R2 count", int'(cnt), 0);
  endtask

  task automatic t_sync_hold();
    drive(1'b1, 1);
    check("R1 sync one edge", int'(sync_out), 0);
    step(1);
    check("R1 sync two edges", int'(sync_out), 1);
    step(4);
    drive(1'b0, 2);
    check("R1 sync fall", int'(sync_out), 0);
    step(3);
    check("R3 clean transitions", int'({p_err, s_err, g_err}), 0);
  endtask

  task automatic t_pulse3();
    drive(1'b1, 3);
    drive(1'b0, 5);
    check("R3 three-edge pulse flags", int'({p_err, s_err, g_err}), 0);
    check("R3 three-edge pulse count", int'(cnt), 0);
  endtask

  task automatic t_pulse(int w);
    drive(1'b1, w);
    drive(1'b0, 1);
    check("R4 pulse flag timing", int'(p_err), 0);
    step(1);
    check("R4 short pulse flag", int'(p_err), 1);
    check("R4 no chatter flag", int'(s_err), 0);
    check("R4 pulse count", int'(cnt), 1);
    step(4);
    check("R7 pulse flag sticky", int'(p_err), 1);
    do_clear();
    check("R7 clear flags", int'({p_err, s_err, g_err}), 0);
    check("R7 clear count", int'(cnt), 0);
  endtask

  task automatic t_chatter();
    drive(1'b1, 1);
    drive(1'b0, 1);
    drive(1'b1, 1);
    check("R5 chatter flag timing", int'(s_err), 0);
    step(1);
    check("R5 chatter flag", int'(s_err), 1);
    check("R5 pulse flag", int'(p_err), 1);
    check("R5 count two", int'(cnt), 2);
    step(5);
    drive(1'b0, 5);
    check("R3 long levels after chatter", int'(cnt), 2);
    do_clear();
  endtask

  task automatic t_glitch();
    step(2);
    glitch_once();
    check("R6 glitch flag", int'(g_err), 1);
    check("R6 no pulse flag", int'(p_err), 0);
    check("R6 sync untouched", int'(sync_out), 0);
    check("R8 glitch count", int'(cnt), 1);
    step(1);
    glitch_once();
    check("R8 second glitch count", int'(cnt), 2);
    do_clear();
  endtask

  task automatic t_clear_priority();
    step(2);
    clr = 1'b1;
    glitch_once();
    clr = 1'b0;
    check("R7 clear wins flag", int'(g_err), 0);
    check("R7 clear wins count", int'(cnt), 0);
    step(2);
    check("R7 event dropped", int'(cnt), 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 20; i++) glitch_once();
    check("R8 saturate", int'(cnt), (1 << CW) - 1);
    step(3);
    check("R8 stays saturated", int'(cnt), (1 << CW) - 1);
    do_clear();
    check("R7 clear after saturate", int'(cnt), 0);
  endtask

  initial begin
    t_reset();
    t_sync_hold();
    t_pulse3();
    t_pulse(1);
    t_pulse(2);
    t_chatter();
    t_glitch();
    t_clear_priority();
    t_saturate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule